// File: doc/BRIEF.md
# Regulator Power-Good Monitor

This block drives the power-good output of a voltage regulator. Each clock it compares a digitised output-voltage code with a target code, using a lower and an upper tolerance given in percent of the target. It also looks at a fault flag. When all of these are good at once, the block starts a qualification delay that is counted in milliseconds from a one-cycle tick input. Power-good asserts only when that whole delay has passed with no interruption. If any condition is lost, power-good drops at once and the delay starts again from zero.

The delay length normally comes from the soft-start ramp time setting. A select input can switch it to a separately written delay value instead. A polarity input decides whether "good" is shown as a high or a low level on the output pin. All settings are plain register inputs; the ADC and the bus that writes the settings sit outside the block.

Top module: `pgmon_top`

## Requirements
- R1: Power-good rises only after a clock edge at which the voltage was in the window and no fault was present.
- R2: The voltage passes the lower check when `vout_code >= target - floor(target*tol_low_pct/100)` (the bound is inclusive). A value of 10 gives the default rule of at most 10% below target. A `tol_low_pct` of 100 or more disables the lower check.
- R3: The voltage passes the upper check when `vout_code <= target + floor(target*tol_high_pct/100)` (the bound is inclusive).
- R4: While `fault` is 1, power-good is not asserted.
- R5: With a delay of N ms (N > 0), the delay counter advances on each edge where `ms_tick` is 1 and the conditions hold. Power-good asserts on the first edge after N such ticks have been counted.
- R6: When `use_own_delay` is 0 the delay is `ramp_ms`. When it is 1 the delay is `own_delay_ms`.
- R7: If the conditions fail while the delay is counting, the count clears. A later qualification must count a full new delay.
- R8: Once asserted, power-good drops on the first clock edge at which the conditions fail, with no delay.
- R9: With a delay of 0, power-good asserts on the first clock edge at which the conditions hold.
- R10: `pg_pin` equals the internal good state when `pg_active_high` is 1, and its inverse when it is 0. This is combinational with respect to `pg_active_high`.
- R11: During reset the internal state is not-good, so `pg_pin` shows the inactive level for the current polarity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ms_tick | input | 1 | One-cycle pulse per millisecond |
| vout_code | input | VW | Measured output-voltage code |
| vtarget_code | input | VW | Target-voltage code |
| fault | input | 1 | A fault condition is present |
| ramp_ms | input | DW | Soft-start ramp time in ms (default delay) |
| own_delay_ms | input | DW | Independent delay value in ms |
| use_own_delay | input | 1 | 1 selects `own_delay_ms` as the delay |
| tol_low_pct | input | PW | Allowed drop below target, in percent |
| tol_high_pct | input | PW | Allowed rise above target, in percent |
| pg_active_high | input | 1 | 1 = good shown as high on the pin |
| pg_pin | output | 1 | Power-good output pin |

## Verification
Every state change caused by voltage, fault, tick or delay inputs shows on `pg_pin` one rising edge after those inputs are applied. A change of polarity shows on the pin within the same cycle. The driver applies inputs at a falling edge and queues the expected pin level for the next rising edge. The monitor samples 2 ns after each rising edge, so each queued item is compared against exactly the edge it refers to. The expected levels come from a millisecond-count model that uses the multiplied form of the tolerance inequalities, not the divided form.

// File: rtl/pgmon_pkg.sv
package pgmon_pkg;

  localparam int unsigned CALC_W = 32;

  // Lowest acceptable code: target less a percentage of it (0 when the check is off).
  function automatic logic [CALC_W-1:0] pg_floor_limit(input logic [CALC_W-1:0] tgt,
                                                        input logic [CALC_W-1:0] pct);
    if (pct >= 32'd100) return '0;
    return tgt - ((tgt * pct) / 32'd100);
  endfunction

  // Highest acceptable code: target plus a percentage of it.
  function automatic logic [CALC_W-1:0] pg_ceil_limit(input logic [CALC_W-1:0] tgt,
                                                       input logic [CALC_W-1:0] pct);
    return tgt + ((tgt * pct) / 32'd100);
  endfunction

endpackage

// File: rtl/pgmon_window.sv
module pgmon_window
  import pgmon_pkg::*;
#(
  parameter int VW = 12,
  parameter int PW = 7
) (
  input  logic [VW-1:0] vout_code,
  input  logic [VW-1:0] vtarget_code,
  input  logic [PW-1:0] tol_low_pct,
  input  logic [PW-1:0] tol_high_pct,
  input  logic          fault,
  output logic          above_floor,
  output logic          below_ceil,
  output logic          cond_ok
);

  logic [CALC_W-1:0] lim_lo, lim_hi, v_ext;

  assign v_ext  = CALC_W'(vout_code);
  assign lim_lo = pg_floor_limit(CALC_W'(vtarget_code), CALC_W'(tol_low_pct));
  assign lim_hi = pg_ceil_limit(CALC_W'(vtarget_code), CALC_W'(tol_high_pct));

  assign above_floor = (v_ext >= lim_lo);
  assign below_ceil  = (v_ext <= lim_hi);
  assign cond_ok     = above_floor && below_ceil && !fault;

endmodule

// File: rtl/pgmon_timer.sv
module pgmon_timer #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ms_tick,
  input  logic          cond_ok,
  input  logic [DW-1:0] delay_ms,
  output logic          pg_good,
  output logic [DW-1:0] cnt_q
);

  logic delay_done;
  assign delay_done = (cnt_q >= delay_ms);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      pg_good <= 1'b0;
    end else if (!cond_ok) begin
      cnt_q   <= '0;
      pg_good <= 1'b0;
    end else if (!pg_good) begin
      if (delay_done)   pg_good <= 1'b1;
      else if (ms_tick) cnt_q   <= cnt_q + 1'b1;
    end
  end

  AST_DROP_FAST: assert property (@(posedge clk) disable iff (!rst_n)
    !cond_ok |=> !pg_good); // R8
  AST_RESTART_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    !cond_ok |=> (cnt_q == '0)); // R7
  AST_TICK_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (cond_ok && !pg_good && (cnt_q < delay_ms) && ms_tick) |=> (cnt_q == DW'($past(cnt_q) + 1'b1))); // R5
  AST_ZERO_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
    (cond_ok && (delay_ms == '0)) |=> pg_good); // R9
  AST_RISE_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pg_good) |-> $past(cond_ok)); // R1

endmodule

// File: rtl/pgmon_top.sv
module pgmon_top #(
  parameter int VW = 12,
  parameter int DW = 8,
  parameter int PW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ms_tick,
  input  logic [VW-1:0] vout_code,
  input  logic [VW-1:0] vtarget_code,
  input  logic          fault,
  input  logic [DW-1:0] ramp_ms,
  input  logic [DW-1:0] own_delay_ms,
  input  logic          use_own_delay,
  input  logic [PW-1:0] tol_low_pct,
  input  logic [PW-1:0] tol_high_pct,
  input  logic          pg_active_high,
  output logic          pg_pin
);

  logic          above_floor, below_ceil, cond_ok, pg_good;
  logic [DW-1:0] delay_sel, cnt_q;

  assign delay_sel = use_own_delay ? own_delay_ms : ramp_ms;

  pgmon_window #(.VW(VW), .PW(PW)) u_window (
    .vout_code    (vout_code),
    .vtarget_code (vtarget_code),
    .tol_low_pct  (tol_low_pct),
    .tol_high_pct (tol_high_pct),
    .fault        (fault),
    .above_floor  (above_floor),
    .below_ceil   (below_ceil),
    .cond_ok      (cond_ok)
  );

  pgmon_timer #(.DW(DW)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .ms_tick  (ms_tick),
    .cond_ok  (cond_ok),
    .delay_ms (delay_sel),
    .pg_good  (pg_good),
    .cnt_q    (cnt_q)
  );

  assign pg_pin = pg_active_high ? pg_good : !pg_good;

  AST_FAULT_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> !pg_good); // R4
  AST_LOW_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    !above_floor |=> !pg_good); // R2
  AST_HIGH_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    !below_ceil |=> !pg_good); // R3

endmodule

// File: tb/pgmon_top_tb_top.sv
module pgmon_top_tb_top;

  localparam int VW = 12;
  localparam int DW = 8;
  localparam int PW = 7;

  typedef struct {
    logic  exp;
    string req;
  } sb_item_t;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ms_tick = 1'b0;
  logic [VW-1:0] vout_code = '0;
  logic [VW-1:0] vtarget_code = 12'd1000;
  logic          fault = 1'b0;
  logic [DW-1:0] ramp_ms = '0;
  logic [DW-1:0] own_delay_ms = '0;
  logic          use_own_delay = 1'b0;
  logic [PW-1:0] tol_low_pct = 7'd10;
  logic [PW-1:0] tol_high_pct = 7'd10;
  logic          pg_active_high = 1'b1;
  logic          pg_pin;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;
  sb_item_t sb_q[$];

  int m_ticks = 0;
  bit m_good  = 0;

  always #5 clk = ~clk;

  pgmon_top #(.VW(VW), .DW(DW), .PW(PW)) dut_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .ms_tick        (ms_tick),
    .vout_code      (vout_code),
    .vtarget_code   (vtarget_code),
    .fault          (fault),
    .ramp_ms        (ramp_ms),
    .own_delay_ms   (own_delay_ms),
    .use_own_delay  (use_own_delay),
    .tol_low_pct    (tol_low_pct),
    .tol_high_pct   (tol_high_pct),
    .pg_active_high (pg_active_high),
    .pg_pin         (pg_pin)
  );

  task automatic check(input logic act, input logic exp, input string req);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: pg_pin=%b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  // Driver: apply one cycle of inputs, queue the pin level due after the next rising edge.
  task automatic cyc(input int v, input bit f, input bit tk, input string req);
    int lo_pct, hi_pct, tgt, dly;
    bit ok;
    sb_item_t it;
    vout_code = VW'(v);
    fault     = f;
    ms_tick   = tk;
    tgt    = int'(vtarget_code);
    lo_pct = int'(tol_low_pct);
    hi_pct = int'(tol_high_pct);
    dly    = use_own_delay ? int'(own_delay_ms) : int'(ramp_ms);
    ok = !f && (v * 100 <= tgt * (100 + hi_pct)) &&
         ((lo_pct >= 100) || (v * 100 >= tgt * (100 - lo_pct)));
    if (!ok) begin
      m_ticks = 0;
      m_good  = 0;
    end else if (!m_good) begin
      if (m_ticks >= dly) m_good = 1;
      else if (tk) m_ticks++;
    end
    it.exp = pg_active_high ? m_good : !m_good;
    it.req = req;
    sb_q.push_back(it);
    @(negedge clk);
  endtask

  // Monitor: compare each queued expectation just after its rising edge.
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (sb_q.size() > 0) begin
        sb_item_t it;
        it = sb_q.pop_front();
        check(pg_pin, it.exp, it.req);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: run did not finish, actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    check(pg_pin, 1'b0, "R11 active-high inactive in reset");
    pg_active_high = 1'b0;
    #1;
    check(pg_pin, 1'b1, "R11 active-low inactive in reset");
    @(negedge clk);
    pg_active_high = 1'b1;
    rst_n = 1'b1;

    // zero delay and window edges
    cyc(1000, 0, 0, "R9");
    cyc(1000, 0, 0, "R1");
    cyc(899,  0, 0, "R2 below floor");
    cyc(900,  0, 0, "R2 at floor");
    cyc(1100, 0, 0, "R3 at ceiling");
    cyc(1101, 0, 0, "R3 above ceiling");
    cyc(1000, 0, 0, "R3 recover");
    cyc(1000, 1, 0, "R4 fault");
    cyc(1000, 0, 0, "R4 fault cleared");
    tol_low_pct = 7'd20;
    cyc(800,  0, 0, "R2 floor 20pct");
    cyc(799,  0, 0, "R2 below floor 20pct");
    tol_low_pct = 7'd100;
    cyc(0,    0, 0, "R2 floor disabled");
    tol_low_pct = 7'd10;

    // ramp-time delay
    ramp_ms = 8'd3;
    cyc(0, 0, 0, "R8 drop");
    for (int i = 0; i < 20; i++) cyc(1000, 0, (i % 4) == 3, "R5");
    cyc(1200, 0, 0, "R8");

    // independent delay
    use_own_delay = 1'b1;
    own_delay_ms  = 8'd1;
    for (int i = 0; i < 8; i++) cyc(1000, 0, (i % 3) == 2, "R6 own delay");
    use_own_delay = 1'b0;
    cyc(0, 0, 0, "R8 drop");
    for (int i = 0; i < 6; i++) cyc(1000, 0, (i % 3) == 2, "R6 ramp delay");

    // restart on loss while counting
    cyc(0, 0, 0, "R7 drop");
    for (int i = 0; i < 6; i++) cyc(1000, 0, (i == 1) || (i == 3), "R7 partial");
    cyc(1000, 1, 0, "R7 interrupt");
    for (int i = 0; i < 16; i++) cyc(1000, 0, (i % 4) == 3, "R7 full restart");

    // polarity
    ramp_ms = 8'd0;
    pg_active_high = 1'b0;
    cyc(1000, 0, 0, "R10 low good");
    cyc(500,  0, 0, "R10 low bad");
    cyc(1000, 0, 0, "R10 low good again");
    pg_active_high = 1'b1;
    cyc(1000, 0, 0, "R10 back high");

    repeat (3) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule